// File: doc/BRIEF.md
# Retirement-Time Instruction Miss Logger

This block keeps a circular history of the instruction-cache misses that a core actually commits. It watches the retire port, which may retire up to `LANES` instructions per cycle. Each retiring instruction carries three things: a flag saying its fetch missed the instruction cache, a flag saying its block came from the prefetch buffer, and the physical block address.

Every qualifying instruction becomes one log entry. Lane 0 is taken before lane 1 within a cycle. An entry is the 38-bit physical address plus one bit saying whether the prefetch buffer supplied the block. Logging happens at commit and not at fetch, so fetches down a mispredicted path never enter the history. Because the addresses are physical, a later replay needs no translation.

Entries are gathered in a staging register, twelve to a 512-bit log block. When the twelfth slot is filled, the whole block is issued as a single write. For every entry, the block also emits an index update that pairs the address with its position in the log. The position counts entries and wraps modulo the log size.

Top module: `mlog_retire_logger`

## Requirements
- R1: After reset no write and no index update is issued, and the first entry logged afterwards takes log position 0 in block 0.
- R2: A lane produces an entry only when its valid is high and at least one of its fetch-miss and prefetch-hit flags is high. Any other lane input produces no index update, no write and no advance of the position.
- R3: Each entry produces an index update on its own lane in the cycle after retirement, carrying the entry's address and log position.
- R4: Positions are handed out consecutively. When both lanes log in one cycle, lane 0 receives the lower position.
- R5: Each entry is 39 bits: address in bits 37:0 and the prefetch-hit flag in bit 38. An entry logged from a plain miss has bit 38 clear.
- R6: In a written block, the entry at position p occupies bits [39*(p mod 12) +: 39], and bits 511:468 are zero.
- R7: One cycle after the entry at a position p with p mod 12 = 11 is logged, exactly one write is issued with block index p/12, carrying all twelve entries of that block.
- R8: After position 12*LOG_BLOCKS-1 the position wraps to 0 and the block index to 0.
- R9: A block that is only partly filled is never written, including when reset arrives mid-block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ret_valid | input | LANES | Lane retires an instruction |
| ret_miss | input | LANES | Instruction missed the instruction cache at fetch |
| ret_pbhit | input | LANES | Instruction's block was supplied by the prefetch buffer |
| ret_addr | input | LANES*38 | Physical block address per lane (lane 0 in low bits) |
| idx_valid | output | LANES | Index update valid per lane |
| idx_addr | output | LANES*38 | Address of each index update |
| idx_pos | output | LANES*POS_W | Log position of each index update |
| wr_valid | output | 1 | Log block write request |
| wr_blk | output | clog2(LOG_BLOCKS) | Log block index of the write |
| wr_data | output | 512 | Packed block payload |

## Verification
The hardest case to reach is a block boundary that falls between the two lanes of one cycle. In that cycle, lane 0 fills slot 11 and lane 1 must open slot 0 of the next block without corrupting the payload that is being written. A second hard case is the same split landing exactly on the wrap from the last log block back to block 0. To reach both, the stimulus alternates single-lane and dual-lane phases. This shifts the block alignment between odd and even positions. A long dual-lane phase then runs past the full 8196-entry log, so the wrap is crossed. A reset issued while a block is half filled confirms that no partial block is ever written.

// File: rtl/mlog_pkg.sv
package mlog_pkg;
    localparam int ADDR_W = 38;
    localparam int SLOTS  = 12;
    localparam int ENT_W  = ADDR_W + 1;
    localparam int BLK_W  = 512;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int PAD_W  = BLK_W - SLOTS * ENT_W;

    typedef logic [ENT_W-1:0] log_ent_t;
    typedef log_ent_t [SLOTS-1:0] stage_t;
endpackage

// File: rtl/mlog_qualify.sv
module mlog_qualify
    import mlog_pkg::*;
(
    input  logic              valid,
    input  logic              miss,
    input  logic              pbhit,
    input  logic [ADDR_W-1:0] addr,
    output logic              log_en,
    output log_ent_t          entry
);
    // Only committed instructions that missed, or were fed by the prefetch buffer, are recorded.
    assign log_en = valid && (miss || pbhit);
    assign entry  = {pbhit, addr};
endmodule

// File: rtl/mlog_advance.sv
module mlog_advance
    import mlog_pkg::*;
#(
    parameter int LOG_BLOCKS = 683,
    parameter int BIW        = 10,
    parameter int POS_W      = 15
) (
    input  logic [BIW-1:0]    blk,
    input  logic [SLOT_W-1:0] slot,
    input  logic [POS_W-1:0]  pos,
    output logic [BIW-1:0]    nblk,
    output logic [SLOT_W-1:0] nslot,
    output logic [POS_W-1:0]  npos,
    output logic              fill
);
    localparam int LAST_POS = LOG_BLOCKS * SLOTS - 1;
    localparam int LAST_BLK = LOG_BLOCKS - 1;

    always_comb begin
        fill  = (slot == SLOT_W'(SLOTS - 1));
        nslot = fill ? '0 : slot + 1'b1;
        if (fill) begin
            nblk = (blk == BIW'(LAST_BLK)) ? '0 : blk + 1'b1;
        end else begin
            nblk = blk;
        end
        npos = (pos == POS_W'(LAST_POS)) ? '0 : pos + 1'b1;
    end
endmodule

// File: rtl/mlog_retire_logger.sv
module mlog_retire_logger
    import mlog_pkg::*;
#(
    parameter int LANES      = 2,
    parameter int LOG_BLOCKS = 683,
    parameter int POS_W      = 15,
    parameter int BIW        = (LOG_BLOCKS > 1) ? $clog2(LOG_BLOCKS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        ret_valid,
    input  logic [LANES-1:0]        ret_miss,
    input  logic [LANES-1:0]        ret_pbhit,
    input  logic [LANES*ADDR_W-1:0] ret_addr,
    output logic [LANES-1:0]        idx_valid,
    output logic [LANES*ADDR_W-1:0] idx_addr,
    output logic [LANES*POS_W-1:0]  idx_pos,
    output logic                    wr_valid,
    output logic [BIW-1:0]          wr_blk,
    output logic [BLK_W-1:0]        wr_data
);
    typedef struct packed {
        logic [BIW-1:0]          blk;
        logic [SLOT_W-1:0]       slot;
        logic [POS_W-1:0]        pos;
        stage_t                  stage;
        logic                    wr_v;
        logic [BIW-1:0]          wr_blk;
        logic [BLK_W-1:0]        wr_data;
        logic [LANES-1:0]        ix_v;
        logic [LANES*ADDR_W-1:0] ix_addr;
        logic [LANES*POS_W-1:0]  ix_pos;
    } st_t;

    st_t st_d, st_q;

    // Pointer chain: element l is the write point seen by lane l.
    logic [BIW-1:0]    c_blk  [LANES+1];
    logic [SLOT_W-1:0] c_slot [LANES+1];
    logic [POS_W-1:0]  c_pos  [LANES+1];
    logic [BIW-1:0]    a_blk  [LANES];
    logic [SLOT_W-1:0] a_slot [LANES];
    logic [POS_W-1:0]  a_pos  [LANES];
    logic [LANES-1:0]  fill;
    logic [LANES-1:0]  log_en;
    log_ent_t          ent    [LANES];

    assign c_blk[0]  = st_q.blk;
    assign c_slot[0] = st_q.slot;
    assign c_pos[0]  = st_q.pos;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mlog_qualify u_qual (
            .valid  (ret_valid[g]),
            .miss   (ret_miss[g]),
            .pbhit  (ret_pbhit[g]),
            .addr   (ret_addr[g*ADDR_W +: ADDR_W]),
            .log_en (log_en[g]),
            .entry  (ent[g])
        );

        mlog_advance #(
            .LOG_BLOCKS (LOG_BLOCKS),
            .BIW        (BIW),
            .POS_W      (POS_W)
        ) u_adv (
            .blk   (c_blk[g]),
            .slot  (c_slot[g]),
            .pos   (c_pos[g]),
            .nblk  (a_blk[g]),
            .nslot (a_slot[g]),
            .npos  (a_pos[g]),
            .fill  (fill[g])
        );

        assign c_blk[g+1]  = log_en[g] ? a_blk[g]  : c_blk[g];
        assign c_slot[g+1] = log_en[g] ? a_slot[g] : c_slot[g];
        assign c_pos[g+1]  = log_en[g] ? a_pos[g]  : c_pos[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.wr_v = 1'b0;
        st_d.ix_v = '0;
        st_d.blk  = c_blk[LANES];
        st_d.slot = c_slot[LANES];
        st_d.pos  = c_pos[LANES];
        // Lanes are walked in program order; a completed block is captured before the next lane reuses slot 0.
        for (int l = 0; l < LANES; l++) begin
            if (log_en[l]) begin
                st_d.stage[c_slot[l]]               = ent[l];
                st_d.ix_v[l]                        = 1'b1;
                st_d.ix_addr[l*ADDR_W +: ADDR_W]    = ent[l][ADDR_W-1:0];
                st_d.ix_pos[l*POS_W +: POS_W]       = c_pos[l];
                if (fill[l]) begin
                    st_d.wr_v    = 1'b1;
                    st_d.wr_blk  = c_blk[l];
                    st_d.wr_data = {{PAD_W{1'b0}}, st_d.stage};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx_valid = st_q.ix_v;
    assign idx_addr  = st_q.ix_addr;
    assign idx_pos   = st_q.ix_pos;
    assign wr_valid  = st_q.wr_v;
    assign wr_blk    = st_q.wr_blk;
    assign wr_data   = st_q.wr_data;
endmodule

// File: rtl/mlog_checker.sv
module mlog_checker
    import mlog_pkg::*;
#(
    parameter int LANES      = 2,
    parameter int LOG_BLOCKS = 683,
    parameter int POS_W      = 15,
    parameter int BIW        = 10
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [LANES-1:0]       ret_valid,
    input logic [LANES-1:0]       ret_miss,
    input logic [LANES-1:0]       ret_pbhit,
    input logic [LANES-1:0]       idx_valid,
    input logic [LANES*POS_W-1:0] idx_pos,
    input logic                   wr_valid,
    input logic [BIW-1:0]         wr_blk,
    input logic [BLK_W-1:0]       wr_data
);
    localparam int LAST_POS = LOG_BLOCKS * SLOTS - 1;

    logic end_match;
    always_comb begin
        end_match = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (idx_valid[l] && (int'(idx_pos[l*POS_W +: POS_W]) % SLOTS == SLOTS - 1)
                && (int'(wr_blk) == int'(idx_pos[l*POS_W +: POS_W]) / SLOTS)) begin
                end_match = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        a_r2_only_qualified: assert property (@(posedge clk) disable iff (!rst_n)
            idx_valid[g] |-> $past(ret_valid[g] && (ret_miss[g] || ret_pbhit[g])));

        a_r8_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
            idx_valid[g] |-> (int'(idx_pos[g*POS_W +: POS_W]) <= LAST_POS));

        a_r7_slot_end_writes: assert property (@(posedge clk) disable iff (!rst_n)
            (idx_valid[g] && (int'(idx_pos[g*POS_W +: POS_W]) % SLOTS == SLOTS - 1)) |-> wr_valid);

        if (g > 0) begin : g_pair
            a_r4_lane_order: assert property (@(posedge clk) disable iff (!rst_n)
                (idx_valid[g] && idx_valid[g-1]) |->
                (int'(idx_pos[g*POS_W +: POS_W]) ==
                 ((int'(idx_pos[(g-1)*POS_W +: POS_W]) == LAST_POS) ? 0
                   : int'(idx_pos[(g-1)*POS_W +: POS_W]) + 1)));
        end
    end

    a_r7_write_has_end: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> end_match);

    a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data[BLK_W-1:SLOTS*ENT_W] == '0));
endmodule

bind mlog_retire_logger mlog_checker #(
    .LANES      (LANES),
    .LOG_BLOCKS (LOG_BLOCKS),
    .POS_W      (POS_W),
    .BIW        (BIW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ret_valid (ret_valid),
    .ret_miss  (ret_miss),
    .ret_pbhit (ret_pbhit),
    .idx_valid (idx_valid),
    .idx_pos   (idx_pos),
    .wr_valid  (wr_valid),
    .wr_blk    (wr_blk),
    .wr_data   (wr_data)
);

// File: tb/mlog_retire_logger_tb.sv
module mlog_retire_logger_tb;
    localparam int LANES   = 2;
    localparam int BLOCKS  = 683;
    localparam int POS_W   = 15;
    localparam int BIW     = $clog2(BLOCKS);
    localparam int AW      = 38;
    localparam int EW      = 39;
    localparam int SLOTS   = 12;
    localparam int ENTRIES = BLOCKS * SLOTS;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [LANES-1:0]     ret_valid = '0;
    logic [LANES-1:0]     ret_miss = '0;
    logic [LANES-1:0]     ret_pbhit = '0;
    logic [LANES*AW-1:0]  ret_addr = '0;
    logic [LANES-1:0]     idx_valid;
    logic [LANES*AW-1:0]  idx_addr;
    logic [LANES*POS_W-1:0] idx_pos;
    logic                 wr_valid;
    logic [BIW-1:0]       wr_blk;
    logic [511:0]         wr_data;

    always #4 clk = ~clk;

    mlog_retire_logger #(
        .LANES      (LANES),
        .LOG_BLOCKS (BLOCKS),
        .POS_W      (POS_W)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ret_valid (ret_valid),
        .ret_miss  (ret_miss),
        .ret_pbhit (ret_pbhit),
        .ret_addr  (ret_addr),
        .idx_valid (idx_valid),
        .idx_addr  (idx_addr),
        .idx_pos   (idx_pos),
        .wr_valid  (wr_valid),
        .wr_blk    (wr_blk),
        .wr_data   (wr_data)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Behavioural model state
    int           mpos = 0;
    logic [511:0] mstage = '0;
    bit           wrapped = 0;
    bit           e_iv [LANES];
    logic [AW-1:0] e_ia [LANES];
    int           e_ip [LANES];
    bit           e_wv = 0;
    int           e_wb = 0;
    logic [511:0] e_wd = '0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mpos = 0;
        mstage = '0;
        e_wv = 0;
        for (int l = 0; l < LANES; l++) e_iv[l] = 0;
    endtask

    task automatic model_step();
        e_wv = 0;
        for (int l = 0; l < LANES; l++) begin
            e_iv[l] = 0;
            if (ret_valid[l] && (ret_miss[l] || ret_pbhit[l])) begin
                int s;
                s = mpos % SLOTS;
                e_iv[l] = 1;
                e_ia[l] = ret_addr[l*AW +: AW];
                e_ip[l] = mpos;
                mstage[s*EW +: EW] = {ret_pbhit[l], ret_addr[l*AW +: AW]};
                if (s == SLOTS - 1) begin
                    e_wv = 1;
                    e_wb = mpos / SLOTS;
                    e_wd = mstage;
                    mstage = '0;
                end
                if (mpos == ENTRIES - 1) begin
                    mpos = 0;
                    wrapped = 1;
                end else begin
                    mpos++;
                end
            end
        end
    endtask

    task automatic compare();
        for (int l = 0; l < LANES; l++) begin
            chk(idx_valid[l] == e_iv[l], "R2", "idx_valid", idx_valid[l], e_iv[l]);
            if (e_iv[l] && idx_valid[l]) begin
                chk(idx_addr[l*AW +: AW] == e_ia[l], "R3", "idx_addr",
                    idx_addr[l*AW +: AW], e_ia[l]);
                chk(int'(idx_pos[l*POS_W +: POS_W]) == e_ip[l],
                    (wrapped && e_ip[l] < 2) ? "R8" : ((l > 0) ? "R4" : "R3"), "idx_pos",
                    idx_pos[l*POS_W +: POS_W], e_ip[l]);
            end
        end
        chk(wr_valid == e_wv, e_wv ? "R7" : "R9", "wr_valid", wr_valid, e_wv);
        if (e_wv && wr_valid) begin
            chk(int'(wr_blk) == e_wb, (e_wb == 0 && wrapped) ? "R8" : "R7", "wr_blk", wr_blk, e_wb);
            total++;
            if (wr_data !== e_wd) begin
                bad++;
                $display("FAIL R5 R6 wr_data actual=%h expected=%h", wr_data, e_wd);
            end
        end
    endtask

    // mode 0: nothing qualifies, 1: lane 0 misses only, 2: both lanes log, 3: random
    task automatic run(int mode, int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            compare();
            for (int l = 0; l < LANES; l++) begin
                logic [AW-1:0] a;
                a = {$urandom(), $urandom()} & {AW{1'b1}};
                ret_addr[l*AW +: AW] = a;
                case (mode)
                    0: begin
                        ret_valid[l] = $urandom_range(0, 1);
                        ret_miss[l]  = ret_valid[l] ? 1'b0 : 1'($urandom_range(0, 1));
                        ret_pbhit[l] = ret_valid[l] ? 1'b0 : 1'($urandom_range(0, 1));
                    end
                    1: begin
                        ret_valid[l] = (l == 0);
                        ret_miss[l]  = 1'b1;
                        ret_pbhit[l] = 1'b0;
                    end
                    2: begin
                        ret_valid[l] = 1'b1;
                        ret_miss[l]  = 1'b1;
                        ret_pbhit[l] = 1'($urandom_range(0, 1));
                    end
                    default: begin
                        ret_valid[l] = 1'($urandom_range(0, 1));
                        ret_miss[l]  = 1'($urandom_range(0, 1));
                        ret_pbhit[l] = 1'($urandom_range(0, 1));
                    end
                endcase
            end
            model_step();
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(idx_valid == '0, "R1", "idx_valid in reset", idx_valid, 0);
        chk(wr_valid == 1'b0, "R1", "wr_valid in reset", wr_valid, 0);
        rst_n = 1'b1;
        run(0, 40);      // R2 ignored lanes
        run(1, 61);      // single lane shifts alignment
        run(2, 4200);    // dual lane, crosses the wrap (R8)
        run(3, 2000);
        run(1, 5);       // leave a partial block
        @(negedge clk);
        compare();
        ret_valid = '0;
        rst_n = 1'b0;    // R9: partial block dropped, R1: pointer restarts
        model_reset();
        @(negedge clk);
        chk(wr_valid == 1'b0, "R9", "wr_valid after mid-block reset", wr_valid, 0);
        chk(idx_valid == '0, "R1", "idx_valid after mid-block reset", idx_valid, 0);
        rst_n = 1'b1;
        run(2, 6);       // R1: first entries take positions 0 and 1
        run(3, 300);
        @(negedge clk);
        compare();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule